// File: doc/BRIEF.md
# Link Error Counter Bank

This block keeps a bank of independent error counters for an E1 line receiver. Each counter watches one single-cycle error pulse, such as a bipolar violation, a CRC failure, an errored frame alignment word or a remote E-bit, and counts it. Software reaches the bank through a simple register port. Through that port it can read any counter, load any counter with a chosen value, mask interrupts and read two flag registers that clear themselves when read.

Every counter has two flags. The first is an event flag, raised whenever an error is counted. The second is an overflow flag, raised when the counter wraps from all ones to zero. The interrupt line is the OR of every flag whose mask bit is clear. A global clear bit forces every counter to zero for as long as it stays set.

A one-second tick comes from outside the block. On each tick the block copies the first four counters into a separate snapshot page. Software can then read a consistent one-second picture while counting carries on.

Top module: `err_cnt_bank`

## Requirements
- R1: Reset sets every counter to zero. Each of the `NUM_CNT` counters goes up by one at every clock edge where its bit of `errIn` is 1. Register addresses 0 to `NUM_CNT`-1 read counter 0 to `NUM_CNT`-1.
- R2: A write to address i, where i is below `NUM_CNT`, loads counter i with the low `CNT_W` bits of `wrData`.
- R3: At every clock edge where `secTick` is 1, counters 0 to `SNAP_N`-1 are copied into snapshot registers. These registers are read at addresses `NUM_CNT`+j. Between ticks the snapshot registers keep their values.
- R4: The global clear is bit 0 of the control register at address 16. While it is 1, every counter is held at zero. While it is 1, error pulses and counter writes are ignored and set no flag.
- R5: Event flags are read at address 19, with bit i belonging to counter i. Every counted pulse sets its flag. A read of address 19 clears all event flags.
- R6: When a counter at its maximum value counts a pulse, it wraps to zero and keeps counting; it never saturates. The wrap sets bit i of the overflow latch at address 20. A read of address 20 clears the latch.
- R7: The event mask is at address 17 and the overflow mask at address 18. A mask bit of 1 blocks that flag. Both masks reset to all ones. `irq` is 1 exactly when some event flag or overflow flag is set and its mask bit is 0.
- R8: With the default width of 8 bits, a counter overflows once for every 256 counted pulses. In general it overflows once for every 2^`CNT_W` pulses.
- R9: When a counter write and that counter's error pulse land on the same edge, the counter takes the written value. The event flag is still set.
- R10: When a flag is set on the same edge as a read that clears its register, the flag is set after the clear. The next read still reports the event.
- R11: `rdData` shows the addressed register one cycle after `rdEn` and holds it until the next read. A read of an address with no register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errIn | input | NUM_CNT | One error pulse per counter |
| secTick | input | 1 | One-second snapshot strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write address |
| wrData | input | max(NUM_CNT,CNT_W) | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 5 | Read address |
| rdData | output | max(NUM_CNT,CNT_W) | Read data, one cycle after rdEn |
| irq | output | 1 | OR of all unmasked flags |

## Verification
The bench builds the bank with nine counters, a snapshot of four and `CNT_W` set to 4. With that width a counter wraps after only sixteen pulses. The stimulus table therefore drives several counters through their wrap, and the wrap-and-continue behaviour of R6 and R8 becomes visible in a short run. The narrow counters also make it cheap to preset a counter to its maximum value and collide its overflow with a clearing read.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CTRL    = 5'd16;
  localparam logic [ADDR_W-1:0] A_EVTMASK = 5'd17;
  localparam logic [ADDR_W-1:0] A_OVFMASK = 5'd18;
  localparam logic [ADDR_W-1:0] A_EVTPEND = 5'd19;
  localparam logic [ADDR_W-1:0] A_OVFLAT  = 5'd20;

  typedef struct packed {
    logic cntWrite;
    logic holdClr;
    logic snapTake;
    logic evtRdClr;
    logic ovfRdClr;
  } dpStrobe_t;
endpackage

// File: rtl/ecb_ctrl.sv
module ecb_ctrl
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 9,
  parameter int CNT_W   = 8,
  parameter int SNAP_N  = 4,
  parameter int DATA_W  = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          secTick,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             rdAddr,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [SNAP_N-1:0][CNT_W-1:0]  snapVal,
  input  logic [NUM_CNT-1:0]            evtPend,
  input  logic [NUM_CNT-1:0]            ovfLat,
  output dpStrobe_t                     strb,
  output logic [NUM_CNT-1:0]            cntSel,
  output logic [CNT_W-1:0]              wrValue,
  output logic [NUM_CNT-1:0]            evtMask,
  output logic [NUM_CNT-1:0]            ovfMask,
  output logic [DATA_W-1:0]             rdData
);
  logic globalClr;
  logic [DATA_W-1:0] rdNext;

  // control and mask registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalClr <= 1'b0;
      evtMask   <= '1;
      ovfMask   <= '1;
    end else if (wrEn) begin
      if (wrAddr == A_CTRL)    globalClr <= wrData[0];
      if (wrAddr == A_EVTMASK) evtMask   <= wrData[NUM_CNT-1:0];
      if (wrAddr == A_OVFMASK) ovfMask   <= wrData[NUM_CNT-1:0];
    end
  end

  // counter write select, one-hot
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    assign cntSel[i] = wrEn && !globalClr && (wrAddr == ADDR_W'(i));
  end

  assign wrValue       = wrData[CNT_W-1:0];
  assign strb.cntWrite = |cntSel;
  assign strb.holdClr  = globalClr;
  assign strb.snapTake = secTick;
  assign strb.evtRdClr = rdEn && (rdAddr == A_EVTPEND);
  assign strb.ovfRdClr = rdEn && (rdAddr == A_OVFLAT);

  // read mux
  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rdAddr == ADDR_W'(i)) rdNext = DATA_W'(cntVal[i]);
    for (int j = 0; j < SNAP_N; j++)
      if (rdAddr == ADDR_W'(NUM_CNT + j)) rdNext = DATA_W'(snapVal[j]);
    case (rdAddr)
      A_CTRL:    rdNext = DATA_W'(globalClr);
      A_EVTMASK: rdNext = DATA_W'(evtMask);
      A_OVFMASK: rdNext = DATA_W'(ovfMask);
      A_EVTPEND: rdNext = DATA_W'(evtPend);
      A_OVFLAT:  rdNext = DATA_W'(ovfLat);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  // R11: the latch value reaches rdData one cycle after the read
  p_rd_latch_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == A_OVFLAT) |=> (rdData == DATA_W'($past(ovfLat))));

  // R4: no counter write passes while the clear is held
  p_no_write_in_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdClr |-> !strb.cntWrite);
endmodule

// File: rtl/ecb_datapath.sv
module ecb_datapath
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 9,
  parameter int CNT_W   = 8,
  parameter int SNAP_N  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CNT-1:0]            errIn,
  input  dpStrobe_t                     strb,
  input  logic [NUM_CNT-1:0]            cntSel,
  input  logic [CNT_W-1:0]              wrValue,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [SNAP_N-1:0][CNT_W-1:0]  snapVal,
  output logic [NUM_CNT-1:0]            evtPend,
  output logic [NUM_CNT-1:0]            ovfLat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CNT-1:0] evtHit;
  logic [NUM_CNT-1:0] ovfHit;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic doWrite;
    assign doWrite   = strb.cntWrite && cntSel[i];
    assign evtHit[i] = !strb.holdClr && errIn[i];
    assign ovfHit[i] = evtHit[i] && !doWrite && (cntVal[i] == CNT_MAX);

    always_ff @(posedge clk) begin
      if (!rstN || strb.holdClr) cntVal[i] <= '0;
      else if (doWrite)          cntVal[i] <= wrValue;
      else if (errIn[i])         cntVal[i] <= cntVal[i] + CNT_W'(1);
    end

    // R6 R8: wrap to zero and record the overflow
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
      ovfHit[i] |=> (cntVal[i] == '0) && ovfLat[i]);

    // R9: a write beats a same-cycle pulse
    p_preset_r9: assert property (@(posedge clk) disable iff (!rstN)
      (doWrite && !strb.holdClr) |=> (cntVal[i] == $past(wrValue)));
  end

  // flag registers: clear on read, new hits land after the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPend <= '0;
      ovfLat  <= '0;
    end else begin
      evtPend <= (strb.evtRdClr ? '0 : evtPend) | evtHit;
      ovfLat  <= (strb.ovfRdClr ? '0 : ovfLat)  | ovfHit;
    end
  end

  for (genvar j = 0; j < SNAP_N; j++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rstN)              snapVal[j] <= '0;
      else if (strb.snapTake) snapVal[j] <= cntVal[j];
    end
  end

  // R3: snapshot only moves on a tick
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snapTake |=> $stable(snapVal));

  // R4: counters read zero after a held clear
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdClr |=> (cntVal == '0));

  // R10: an event raised during a clearing read survives
  p_evt_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtRdClr && evtHit != '0) |=> ((evtPend & $past(evtHit)) == $past(evtHit)));
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 9,
  parameter int CNT_W   = 8,
  parameter int SNAP_N  = 4,
  localparam int DATA_W = (NUM_CNT > CNT_W) ? NUM_CNT : CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CNT-1:0] errIn,
  input  logic               secTick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  dpStrobe_t                     strb;
  logic [NUM_CNT-1:0]            cntSel;
  logic [CNT_W-1:0]              wrValue;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [SNAP_N-1:0][CNT_W-1:0]  snapVal;
  logic [NUM_CNT-1:0]            evtPend, ovfLat, evtMask, ovfMask;

  ecb_ctrl #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SNAP_N(SNAP_N), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .cntVal(cntVal),
    .snapVal(snapVal), .evtPend(evtPend), .ovfLat(ovfLat), .strb(strb),
    .cntSel(cntSel), .wrValue(wrValue), .evtMask(evtMask), .ovfMask(ovfMask),
    .rdData(rdData)
  );

  ecb_datapath #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SNAP_N(SNAP_N)) uData (
    .clk(clk), .rstN(rstN), .errIn(errIn), .strb(strb), .cntSel(cntSel),
    .wrValue(wrValue), .cntVal(cntVal), .snapVal(snapVal),
    .evtPend(evtPend), .ovfLat(ovfLat)
  );

  assign irq = |(evtPend & ~evtMask) || |(ovfLat & ~ovfMask);

  // R7: with every mask set the line stays low
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (&evtMask && &ovfMask) |-> !irq);
endmodule

// File: tb/tb_err_cnt_bank.sv
module tb_err_cnt_bank;
  localparam int NUM = 9;
  localparam int CW  = 4;
  localparam int DW  = 9;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rstN = 0, secTick = 0, wrEn = 0, rdEn = 0;
  logic [NUM-1:0] errIn = '0;
  logic [4:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic irq;

  int total = 0, bad = 0;
  int modCnt [NUM];
  logic [NUM-1:0] modEvt = '0, modOvf = '0;
  bit clrOn = 0;
  logic [DW-1:0] got;

  // pattern (bits 16:8) and pulse count (bits 7:0)
  localparam logic [16:0] VEC [8] = '{
    {9'h1FF, 8'd3}, {9'h001, 8'd5}, {9'h0AA, 8'd10}, {9'h155, 8'd2},
    {9'h100, 8'd20}, {9'h00F, 8'd1}, {9'h0F0, 8'd7}, {9'h003, 8'd13}};

  err_cnt_bank #(.NUM_CNT(NUM), .CNT_W(CW), .SNAP_N(4)) dut (
    .clk(clk), .rstN(rstN), .errIn(errIn), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .irq(irq));

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input int d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = DW'(d);
    @(negedge clk); wrEn = 0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [DW-1:0] d);
    @(negedge clk); rdEn = 1; rdAddr = a;
    @(negedge clk); rdEn = 0; d = rdData;
    if (a == 5'd19) modEvt = '0;
    if (a == 5'd20) modOvf = '0;
  endtask

  task automatic hit(input logic [NUM-1:0] p);
    for (int i = 0; i < NUM; i++)
      if (p[i] && !clrOn) begin
        modEvt[i] = 1;
        if (modCnt[i] == MAXV) modOvf[i] = 1;
        modCnt[i] = (modCnt[i] + 1) & MAXV;
      end
  endtask

  task automatic pulse(input logic [NUM-1:0] p, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); errIn = p; hit(p);
    end
    @(negedge clk); errIn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM; i++) modCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state
    check("R7 irq after reset", int'(irq), 0);
    regRead(5'd0, got); check("R1 counter reset", int'(got), 0);
    regRead(5'd20, got); check("R6 latch reset", int'(got), 0);

    // table walk, all masks still set
    for (int k = 0; k < 8; k++) pulse(VEC[k][16:8], int'(VEC[k][7:0]));
    check("R7 masked irq stays low", int'(irq), 0);
    for (int i = 0; i < NUM; i++) begin
      regRead(5'(i), got);
      check($sformatf("R1 R8 counter %0d", i), int'(got), modCnt[i]);
    end
    begin
      logic [NUM-1:0] expOvf, expEvt;
      expOvf = modOvf; expEvt = modEvt;
      regRead(5'd20, got); check("R6 overflow latch", int'(got), int'(expOvf));
      regRead(5'd20, got); check("R6 latch cleared by read", int'(got), 0);
      regRead(5'd19, got); check("R5 event flags", int'(got), int'(expEvt));
      regRead(5'd19, got); check("R5 flags cleared by read", int'(got), 0);
    end

    // snapshot
    begin
      int s [4];
      for (int j = 0; j < 4; j++) s[j] = modCnt[j];
      @(negedge clk); secTick = 1;
      @(negedge clk); secTick = 0;
      pulse('1, 1);
      for (int j = 0; j < 4; j++) begin
        regRead(5'(9 + j), got);
        check($sformatf("R3 snapshot %0d", j), int'(got), s[j]);
      end
      regRead(5'd0, got); check("R1 counting goes on after tick", int'(got), modCnt[0]);
    end

    // preset
    regWrite(5'd2, 9); modCnt[2] = 9;
    regRead(5'd2, got); check("R2 preset", int'(got), 9);

    // write collides with a pulse
    @(negedge clk); wrEn = 1; wrAddr = 5'd5; wrData = 9'd3; errIn = 9'h020;
    @(negedge clk); wrEn = 0; errIn = '0; modCnt[5] = 3; modEvt[5] = 1;
    regRead(5'd5, got); check("R9 write wins", int'(got), 3);
    regRead(5'd19, got); check("R9 event flag still set", int'(got[5]), 1);

    // overflow collides with a clearing read
    regRead(5'd20, got);
    regWrite(5'd7, MAXV); modCnt[7] = MAXV;
    @(negedge clk); rdEn = 1; rdAddr = 5'd20; errIn = 9'h080;
    @(negedge clk); rdEn = 0; errIn = '0; got = rdData;
    check("R11 read shows pre-clear latch", int'(got), 0);
    modOvf = '0; hit(9'h080);
    regRead(5'd20, got); check("R10 overflow kept across read", int'(got), 9'h080);
    regRead(5'd7, got); check("R6 wrapped to zero", int'(got), 0);

    // interrupt masking
    regRead(5'd19, got);
    regWrite(5'd17, 9'h1EF);
    check("R7 no flag no irq", int'(irq), 0);
    pulse(9'h010, 1);
    check("R7 unmasked event irq", int'(irq), 1);
    pulse(9'h001, 1);
    regRead(5'd19, got);
    check("R7 irq drops after read", int'(irq), 0);
    regWrite(5'd17, 9'h1FF);

    // global clear and hold
    regWrite(5'd16, 1); clrOn = 1;
    for (int i = 0; i < NUM; i++) modCnt[i] = 0;
    pulse('1, 2);
    regWrite(5'd0, 5);
    regRead(5'd0, got); check("R4 counter held at zero", int'(got), 0);
    regRead(5'd5, got); check("R4 other counter held", int'(got), 0);
    regRead(5'd19, got); check("R4 no flag while held", int'(got), 0);
    regWrite(5'd16, 0); clrOn = 0;
    pulse(9'h001, 1);
    regRead(5'd0, got); check("R4 counting after release", int'(got), 1);

    regRead(5'd25, got); check("R11 unmapped reads zero", int'(got), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule